// File: doc/BRIEF.md
# CAN Receiver Status Flag Register

This block holds the eight sticky interrupt flags of a CAN controller's receive side. The protocol engine supplies level and pulse conditions. These are the sleep-mode bus activity indication, the receive and transmit error counters, a bus-off status and single-cycle overrun and buffer-full events. The block latches each condition into its own flag bit. Software reads the flags through a small register port and clears a flag by writing 1 to its bit. The clear is refused while the condition that set the flag is still present.

A second register at the same port holds one enable bit per flag. Each flag is ANDed with its enable bit, and the results are gathered onto four interrupt lines: wakeup, error, overrun and receive. A warning flag is held off while a more severe error flag is already latched. A synchronous soft-reset input clears the flags without disturbing the enables. The asynchronous hard reset clears both registers.

Top module: `can_rx_flag_reg`

## Requirements
- R1: Flag bit layout from bit 7 down to bit 0 is wakeup, receiver warning, transmitter warning, receiver error-passive, transmitter error-passive, bus-off, overrun, receive-buffer-full. `reg_rdata` shows the flags when `reg_addr`=0 and the enables when `reg_addr`=1, combinationally.
- R2: When `sleep_mode` and `bus_activity` are both 1 at a rising clock edge, bit 7 is 1 from that edge on. `bus_activity` without `sleep_mode` sets nothing.
- R3: A receive counter above 96 sets bit 6, and a transmit counter above 96 sets bit 5. Either one sets only if bits 4, 3 and 2 are all 0 before that edge. A counter of exactly 96 sets nothing.
- R4: A receive counter above 127 sets bit 4, and a transmit counter above 127 sets bit 3. `bus_off`=1 sets bit 2. A counter of exactly 127 does not set its error-passive bit.
- R5: A one-cycle `rx_overrun` pulse sets bit 1, and a one-cycle `rx_frame_done` pulse sets bit 0. Each flag stays set after its pulse ends.
- R6: A write with `reg_addr`=0 clears, at that edge, every flag whose data bit is 1 and whose set condition is false in that cycle. Data bits of 0 leave their flags unchanged.
- R7: A flag whose set condition is true in the cycle of a write-1 clear stays 1. A set condition always wins over the clear.
- R8: `soft_rst`=1 at an edge clears all eight flags, taking priority over set conditions, and leaves the enables unchanged. `rst_n`=0 asynchronously clears flags and enables.
- R9: A write with `reg_addr`=1 loads the enable register. `irq_wake` = bit 7 AND enable 7. `irq_err` = OR of bits 6..2, each ANDed with its enable. `irq_ovr` = bit 1 AND enable 1. `irq_rxf` = bit 0 AND enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous flag clear |
| reg_addr | input | 1 | 0 selects flags, 1 selects enables |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sleep_mode | input | 1 | Controller is in sleep mode |
| bus_activity | input | 1 | Activity seen on the bus |
| rx_err_cnt | input | 8 | Receive error counter |
| tx_err_cnt | input | 8 | Transmit error counter |
| bus_off | input | 1 | Bus-off status |
| rx_overrun | input | 1 | Receive overrun event pulse |
| rx_frame_done | input | 1 | Receive buffer full event pulse |
| irq_wake | output | 1 | Wakeup interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_ovr | output | 1 | Overrun interrupt |
| irq_rxf | output | 1 | Receive interrupt |

## Verification
Two functions can meet on one bit in the same cycle: a software write-1 clear and a hardware set condition. This covers both an event pulse that lands on a clear and a level condition that is still held. The bench provokes this deliberately by issuing clears while the wakeup condition, a counter above threshold, or an event pulse is active. It then checks that the flag reads back 1. A second collision happens when an error-passive bit and a warning bit become eligible on the same edge, because suppression looks at the flags from before that edge. A soft reset against an active condition is also exercised. A behavioural model judges every cycle, including a long pseudo-random stretch that mixes counter values around 96 and 127 with writes and pulses.

// File: rtl/can_flag_pkg.sv
package can_flag_pkg;
  localparam int NFLAG    = 8;
  localparam int B_WAKE   = 7;
  localparam int B_RWARN  = 6;
  localparam int B_TWARN  = 5;
  localparam int B_RPASS  = 4;
  localparam int B_TPASS  = 3;
  localparam int B_BOFF   = 2;
  localparam int B_OVR    = 1;
  localparam int B_RXF    = 0;

  // flags that hold off the warning flags
  localparam logic [NFLAG-1:0] SEVERE_MASK = 8'b0001_1100;
  // flags gathered onto the error interrupt
  localparam logic [NFLAG-1:0] ERRGRP_MASK = 8'b0111_1100;

  function automatic logic above_lim(input int unsigned cnt, input int unsigned lim);
    return cnt > lim;
  endfunction

  function automatic logic any_masked(input logic [NFLAG-1:0] v, input logic [NFLAG-1:0] m);
    return |(v & m);
  endfunction
endpackage

// File: rtl/can_flag_cond.sv
module can_flag_cond
  import can_flag_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 127
) (
  input  logic [NFLAG-1:0] flags_q,
  input  logic             sleep_mode,
  input  logic             bus_activity,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic             bus_off,
  input  logic             rx_overrun,
  input  logic             rx_frame_done,
  output logic [NFLAG-1:0] cond
);
  logic severe_held;
  logic rx_warn_lvl, tx_warn_lvl, rx_pass_lvl, tx_pass_lvl;

  always_comb begin
    severe_held = any_masked(flags_q, SEVERE_MASK);
    rx_warn_lvl = above_lim(32'(rx_err_cnt), WARN_LIM);
    tx_warn_lvl = above_lim(32'(tx_err_cnt), WARN_LIM);
    rx_pass_lvl = above_lim(32'(rx_err_cnt), PASSIVE_LIM);
    tx_pass_lvl = above_lim(32'(tx_err_cnt), PASSIVE_LIM);
    cond          = '0;
    cond[B_WAKE]  = sleep_mode & bus_activity;
    cond[B_RWARN] = rx_warn_lvl & ~severe_held;
    cond[B_TWARN] = tx_warn_lvl & ~severe_held;
    cond[B_RPASS] = rx_pass_lvl;
    cond[B_TPASS] = tx_pass_lvl;
    cond[B_BOFF]  = bus_off;
    cond[B_OVR]   = rx_overrun;
    cond[B_RXF]   = rx_frame_done;
  end
endmodule

// File: rtl/can_flag_bit.sv
module can_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic set_cond,
  input  logic clr_req,
  output logic flag_q
);
  logic clr_hit;
  logic flag_d;

  always_comb begin
    clr_hit = clr_req & ~set_cond;
    if (soft_clr)      flag_d = 1'b0;
    else if (set_cond) flag_d = 1'b1;
    else if (clr_hit)  flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cond && !soft_clr) |=> flag_q);
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_cond && !soft_clr) |=> !flag_q);
  a_r6_hold_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req && !soft_clr) |=> flag_q);
  a_r8_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !flag_q);
endmodule

// File: rtl/can_flag_irq.sv
module can_flag_irq
  import can_flag_pkg::*;
(
  input  logic [NFLAG-1:0] flags_q,
  input  logic [NFLAG-1:0] en_q,
  output logic             irq_wake,
  output logic             irq_err,
  output logic             irq_ovr,
  output logic             irq_rxf
);
  logic [NFLAG-1:0] pend;

  always_comb begin
    pend     = flags_q & en_q;
    irq_wake = pend[B_WAKE];
    irq_err  = any_masked(pend, ERRGRP_MASK);
    irq_ovr  = pend[B_OVR];
    irq_rxf  = pend[B_RXF];
  end
endmodule

// File: rtl/can_rx_flag_reg.sv
module can_rx_flag_reg
  import can_flag_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic [NFLAG-1:0] reg_wdata,
  output logic [NFLAG-1:0] reg_rdata,
  input  logic             sleep_mode,
  input  logic             bus_activity,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic             bus_off,
  input  logic             rx_overrun,
  input  logic             rx_frame_done,
  output logic             irq_wake,
  output logic             irq_err,
  output logic             irq_ovr,
  output logic             irq_rxf
);
  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] en_q;
  logic [NFLAG-1:0] cond;
  logic [NFLAG-1:0] clr_vec;
  logic             flag_wr, en_wr;

  assign flag_wr = reg_wr & ~reg_addr;
  assign en_wr   = reg_wr &  reg_addr;
  assign clr_vec = flag_wr ? reg_wdata : '0;

  can_flag_cond #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASSIVE_LIM(PASSIVE_LIM)) u_cond (
    .flags_q(flags_q), .sleep_mode(sleep_mode), .bus_activity(bus_activity),
    .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt), .bus_off(bus_off),
    .rx_overrun(rx_overrun), .rx_frame_done(rx_frame_done), .cond(cond)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    can_flag_bit u_bit (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
      .set_cond(cond[i]), .clr_req(clr_vec[i]), .flag_q(flags_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= reg_wdata;
  end

  assign reg_rdata = reg_addr ? en_q : flags_q;

  can_flag_irq u_irq (
    .flags_q(flags_q), .en_q(en_q),
    .irq_wake(irq_wake), .irq_err(irq_err), .irq_ovr(irq_ovr), .irq_rxf(irq_rxf)
  );

  a_r3_no_warn_after_severe: assert property (@(posedge clk) disable iff (!rst_n)
    (any_masked(flags_q, SEVERE_MASK) && !flags_q[B_RWARN]) |=> !flags_q[B_RWARN]);
  a_r8_soft_keeps_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !en_wr) |=> $stable(en_q));
  a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !(irq_wake || irq_err || irq_ovr || irq_rxf));
  a_r2_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q[B_WAKE] && !sleep_mode) |=> !flags_q[B_WAKE]);
endmodule

// File: tb/can_rx_flag_reg_bench.sv
module can_rx_flag_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sleep_mode = 1'b0, bus_activity = 1'b0;
  logic [7:0] rx_err_cnt = '0, tx_err_cnt = '0;
  logic       bus_off = 1'b0, rx_overrun = 1'b0, rx_frame_done = 1'b0;
  logic       irq_wake, irq_err, irq_ovr, irq_rxf;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string cur_req = "R8";
  bit m_flag [8];
  bit m_en [8];

  always #10 clk = ~clk;

  can_rx_flag_reg u_can_rx_flag_reg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_mode(sleep_mode),
    .bus_activity(bus_activity), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .bus_off(bus_off), .rx_overrun(rx_overrun), .rx_frame_done(rx_frame_done),
    .irq_wake(irq_wake), .irq_err(irq_err), .irq_ovr(irq_ovr), .irq_rxf(irq_rxf)
  );

  function automatic logic [7:0] pack(input bit a [8]);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = a[i];
    return v;
  endfunction

  task automatic model_edge();
    bit want [8];
    bit severe;
    severe = m_flag[4] || m_flag[3] || m_flag[2];
    want[7] = sleep_mode && bus_activity;
    want[6] = (int'(rx_err_cnt) > 96) && !severe;
    want[5] = (int'(tx_err_cnt) > 96) && !severe;
    want[4] = int'(rx_err_cnt) > 127;
    want[3] = int'(tx_err_cnt) > 127;
    want[2] = bus_off;
    want[1] = rx_overrun;
    want[0] = rx_frame_done;
    for (int i = 0; i < 8; i++) begin
      if (soft_rst) m_flag[i] = 0;
      else if (want[i]) m_flag[i] = 1;
      else if (reg_wr && !reg_addr && reg_wdata[i]) m_flag[i] = 0;
    end
    if (reg_wr && reg_addr)
      for (int i = 0; i < 8; i++) m_en[i] = reg_wdata[i];
  endtask

  task automatic compare();
    logic [7:0] f, e, exp_rd;
    logic [3:0] exp_irq, got_irq;
    f = pack(m_flag);
    e = pack(m_en);
    exp_rd = reg_addr ? e : f;
    exp_irq = {f[7] & e[7], |(f[6:2] & e[6:2]), f[1] & e[1], f[0] & e[0]};
    got_irq = {irq_wake, irq_err, irq_ovr, irq_rxf};
    vectors++;
    if (reg_rdata !== exp_rd || got_irq !== exp_irq) begin
      miscompares++;
      $display("FAIL %s t=%0t addr=%0d rdata=%h exp %h irq=%b exp %b",
               cur_req, $time, reg_addr, reg_rdata, exp_rd, got_irq, exp_irq);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic look(input logic a);
    reg_addr = a;
    #1 compare();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 8; i++) begin m_flag[i] = 0; m_en[i] = 0; end
    repeat (2) @(negedge clk);
    // R8: hard reset state
    cur_req = "R8"; look(1'b0); look(1'b1);
    rst_n = 1'b1;
    @(negedge clk); compare();

    // R9: enable all interrupts, read back enables (R1 address map)
    cur_req = "R9"; wr(1'b1, 8'hFF); look(1'b1); look(1'b0);

    // R2: bus activity alone does nothing; with sleep sets bit 7
    cur_req = "R2";
    bus_activity = 1'b1; tick();
    sleep_mode = 1'b1; tick();
    bus_activity = 1'b0; tick();
    // R7: clear while condition held is refused
    cur_req = "R7";
    bus_activity = 1'b1; wr(1'b0, 8'h80);
    bus_activity = 1'b0;
    // R6: write 0 no effect, then write 1 clears
    cur_req = "R6"; wr(1'b0, 8'h00); wr(1'b0, 8'h80);
    sleep_mode = 1'b0;

    // R3 boundary: exactly 96 sets nothing, 97 sets warnings
    cur_req = "R3";
    rx_err_cnt = 8'd96; tx_err_cnt = 8'd96; tick();
    tx_err_cnt = 8'd97; tick();
    rx_err_cnt = 8'd97; tick();
    wr(1'b0, 8'h60); // R7: still above, refused
    rx_err_cnt = 8'd0; tx_err_cnt = 8'd0; wr(1'b0, 8'h60);

    // R4: 127 boundary, 128 sets passive and same-edge warning
    cur_req = "R4";
    rx_err_cnt = 8'd127; tick();
    cur_req = "R6"; rx_err_cnt = 8'd0; wr(1'b0, 8'h40);
    cur_req = "R4";
    rx_err_cnt = 8'd130; tick();
    tx_err_cnt = 8'd100; tick();   // R3: suppressed by bit 4
    tx_err_cnt = 8'd200; tick();
    bus_off = 1'b1; tick();
    bus_off = 1'b0;
    cur_req = "R3"; rx_err_cnt = 8'd100; tx_err_cnt = 8'd100; wr(1'b0, 8'h1C);
    tick();  // severity gone: transmitter warning now sets
    rx_err_cnt = 8'd0; tx_err_cnt = 8'd0; cur_req = "R6"; wr(1'b0, 8'hFF);

    // R5: event pulses latch
    cur_req = "R5";
    rx_overrun = 1'b1; tick(); rx_overrun = 1'b0; tick();
    rx_frame_done = 1'b1; tick(); rx_frame_done = 1'b0; tick();
    // R7: pulse coinciding with its clear
    cur_req = "R7"; rx_frame_done = 1'b1; wr(1'b0, 8'h03); rx_frame_done = 1'b0;
    cur_req = "R9"; wr(1'b1, 8'h01); wr(1'b1, 8'h00); wr(1'b1, 8'h7C);

    // R8: soft reset beats active condition and keeps enables
    cur_req = "R8";
    bus_off = 1'b1; tick();
    soft_rst = 1'b1; tick(); tick();
    soft_rst = 1'b0; tick();
    bus_off = 1'b0; look(1'b1); wr(1'b0, 8'hFF);

    // R6 R7 R3 mixed pseudo-random stretch
    cur_req = "R6 R7 R3 R4 R5 R9";
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sleep_mode    = lfsr[0];
      bus_activity  = lfsr[1] & lfsr[2];
      bus_off       = lfsr[3] & lfsr[4] & lfsr[5];
      rx_overrun    = lfsr[6] & lfsr[7];
      rx_frame_done = lfsr[8] & lfsr[2];
      case (lfsr[11:9])
        3'd0: rx_err_cnt = 8'd96;  3'd1: rx_err_cnt = 8'd97;
        3'd2: rx_err_cnt = 8'd127; 3'd3: rx_err_cnt = 8'd128;
        3'd4: rx_err_cnt = 8'd255; default: rx_err_cnt = 8'd0;
      endcase
      case (lfsr[14:12])
        3'd0: tx_err_cnt = 8'd96;  3'd1: tx_err_cnt = 8'd97;
        3'd2: tx_err_cnt = 8'd127; 3'd5: tx_err_cnt = 8'd128;
        default: tx_err_cnt = 8'd0;
      endcase
      reg_wr    = lfsr[15] | lfsr[4];
      reg_addr  = lfsr[5] & lfsr[9] & lfsr[1];
      reg_wdata = {lfsr[3:0], lfsr[15:12]};
      soft_rst  = (lfsr[15:10] == 6'h2A);
      tick();
    end
    reg_wr = 1'b0; soft_rst = 1'b0; sleep_mode = 1'b0; bus_activity = 1'b0;
    bus_off = 1'b0; rx_overrun = 1'b0; rx_frame_done = 1'b0;
    rx_err_cnt = 8'd0; tx_err_cnt = 8'd0;
    tick();

    // R8: hard reset clears enables too
    cur_req = "R8";
    wr(1'b1, 8'hFF); rx_overrun = 1'b1; tick(); rx_overrun = 1'b0;
    #3 rst_n = 1'b0;
    for (int i = 0; i < 8; i++) begin m_flag[i] = 0; m_en[i] = 0; end
    #1 look(1'b1); look(1'b0);
    @(negedge clk); rst_n = 1'b1; tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule